// File: doc/BRIEF.md
# Dual Down-Counting Timer with Event Counting and Toggle Output

This block holds two 8-bit down-counting timers, each backed by its own reload register. Both run from a shared single-cycle tick strobe. The second timer can be switched over to count rising edges on an external event pin instead of ticks. When a running timer steps past zero, it refills from its reload value in that same step. It then raises a sticky interrupt request, which software clears by writing one to the flag bit.

A toggle flop flips on each underflow of a selected timer, which yields that timer's underflow rate divided by two. This flop drives the shared pin through a separate output enable. The pin's synchronised input level stays readable at all times.

Software reaches everything through a flat register port. Writes take effect on the clock edge. Reads are combinational from the addressed register.

Top module: `dual_reload_timer`

## Requirements
- R1: After synchronous reset every readable address (0 to 6) returns zero, `irq_t1`, `irq_t2` and `cnt_oe` are low, and `cnt_out` is low.
- R2: A running timer in tick mode decrements by one on each cycle where `tick_en` is high. Timer 1 runs when control bit 0 (address 0) is set, and timer 2 when control bit 1 is set. The counts read back at addresses 3 (timer 1) and 4 (timer 2).
- R3: A running timer that steps while at zero reloads from its reload register on that same step, so a reload value N gives a period of N+1 steps. The step also sets the timer's interrupt flag.
- R4: The interrupt flags read at address 5 (bit 0 timer 1, bit 1 timer 2) and drive `irq_t1`/`irq_t2`. A flag stays set until a write of one to its bit at address 5. Writing zero leaves it unchanged.
- R5: Reload registers are at address 1 (timer 1) and address 2 (timer 2). A write while the timer is stopped also loads the counter. A write while it runs changes only the reload value, which the counter takes at its next underflow.
- R6: A stopped timer holds its count whatever the steps.
- R7: With control bit 2 set, timer 2 steps once per rising edge of `evt_in`, taking effect on the third clock edge after the input rises, and ignores `tick_en`. Events never step timer 1.
- R8: The toggle flop flips on each underflow of timer 1 when control bit 3 is zero, or of timer 2 when it is one. An underflow of the other timer leaves it unchanged.
- R9: `cnt_out` is the toggle flop state. `cnt_oe` follows control bit 4. The control register reads back as written in bits 4:0.
- R10: Address 6 bit 0 returns `evt_in` after two synchroniser flops, whether or not the output is enabled. Bit 1 returns the toggle state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| tick_en | input | 1 | Count clock enable strobe |
| evt_in | input | 1 | External event / shared pin input level |
| cnt_out | output | 1 | Toggle output to the shared pin |
| cnt_oe | output | 1 | Output enable for the shared pin driver |
| irq_t1 | output | 1 | Timer 1 underflow interrupt request |
| irq_t2 | output | 1 | Timer 2 underflow interrupt request |

## Verification
Writes and tick strobes act on the next rising edge. Counts, flags, the toggle state and the output enable are therefore due one edge after the strobe, and the bench drives every strobe on a falling edge and reads back on the following falling edge. An event edge needs three rising edges before the count moves, and the pin status needs two, so the bench waits exactly that many falling edges before it samples. Reload values are swept and each step's count is predicted by subtraction, along with the flags and the toggle parity.

// File: rtl/drt_pkg.sv
// Package: register map and control bit positions shared by the dual timer.
package drt_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int NUM_TMR = 2;
    localparam int CTRL_W = 5;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL = 3'd0,
        RA_RLD1 = 3'd1,
        RA_RLD2 = 3'd2,
        RA_CNT1 = 3'd3,
        RA_CNT2 = 3'd4,
        RA_FLAG = 3'd5,
        RA_PIN  = 3'd6
    } reg_addr_e;

    // Control bit positions
    localparam int CB_RUN1 = 0;
    localparam int CB_RUN2 = 1;
    localparam int CB_EVT  = 2;
    localparam int CB_TSEL = 3;
    localparam int CB_OE   = 4;
endpackage

// File: rtl/drt_down_counter.sv
// Down counter with reload register.
// Steps down by one on each enabled step while running. Stepping at zero
// reloads it and pulses uf. A reload write while stopped also loads the
// counter. Assumes step is a single-cycle strobe.
module drt_down_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         step,
    input  logic         rld_we,
    input  logic [W-1:0] rld_wdata,
    output logic [W-1:0] count,
    output logic [W-1:0] reload,
    output logic         uf
);
    // Underflow: running step taken at zero
    always_comb uf = run && step && (count == '0);

    // Reload register storage
    always_ff @(posedge clk) begin
        if (!rst_n)      reload <= '0;
        else if (rld_we) reload <= rld_wdata;
    end

    // Counter: preset when stopped, reload on underflow, else decrement
    always_ff @(posedge clk) begin
        if (!rst_n)                count <= '0;
        else if (rld_we && !run)   count <= rld_wdata;
        else if (uf)               count <= reload;
        else if (run && step)      count <= count - 1'b1;
    end

    assert_reload_on_uf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step && count == '0 && !rld_we) |=> count == $past(reload));
    assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step && count != '0) |=> count == W'($past(count) - 1'b1));
    assert_hold_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !rld_we) |=> $stable(count));
endmodule

// File: rtl/drt_evt_sync.sv
// Event input synchroniser.
// Two flops bring evt_in into the clock domain, and a third flop detects
// the rising edge. Assumes events stay high and low for at least one
// clock each.
module drt_evt_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_in,
    output logic level,
    output logic rise
);
    logic s1, s2, s3;

    // Synchroniser and edge-history chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= evt_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // Outputs: synchronised level and one-cycle rise pulse
    always_comb begin
        level = s2;
        rise  = s2 && !s3;
    end

    assert_single_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/drt_toggle.sv
// Toggle flop: flips on each underflow of the selected timer, which halves
// that timer's underflow rate for the shared pin.
module drt_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic uf_a,
    input  logic uf_b,
    input  logic sel_b,
    output logic tgl
);
    logic hit;

    // Choose which underflow drives the flop
    always_comb hit = sel_b ? uf_b : uf_a;

    // Toggle state
    always_ff @(posedge clk) begin
        if (!rst_n)   tgl <= 1'b0;
        else if (hit) tgl <= !tgl;
    end

    assert_tgl_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_b ? uf_b : uf_a) |=> $stable(tgl));
endmodule

// File: rtl/dual_reload_timer.sv
// Top: two reload down-timers. Timer 2 can count synchronised external
// events instead of ticks. Underflows set sticky write-one-to-clear flags
// and can drive a divide-by-two toggle output. Assumes tick_en is a
// single-cycle strobe and that software does not write a running timer's
// reload in the same cycle as its underflow.
module dual_reload_timer
    import drt_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              tick_en,
    input  logic              evt_in,
    output logic              cnt_out,
    output logic              cnt_oe,
    output logic              irq_t1,
    output logic              irq_t2
);
    logic [CTRL_W-1:0]  ctrl;
    logic [NUM_TMR-1:0] flags;
    logic [NUM_TMR-1:0] run_v, step_v, rld_we_v, uf_v;
    logic [TW-1:0]      cnt_v [NUM_TMR];
    logic [TW-1:0]      rld_v [NUM_TMR];
    logic               evt_lvl, evt_rise, tgl;
    logic               flag_wr;

    // Control register write
    always_ff @(posedge clk) begin
        if (!rst_n)                          ctrl <= '0;
        else if (wr_en && addr == RA_CTRL)   ctrl <= wdata[CTRL_W-1:0];
    end

    // Per-timer run, step and reload-write decode
    always_comb begin
        run_v[0]    = ctrl[CB_RUN1];
        run_v[1]    = ctrl[CB_RUN2];
        step_v[0]   = tick_en;
        step_v[1]   = ctrl[CB_EVT] ? evt_rise : tick_en;
        rld_we_v[0] = wr_en && addr == RA_RLD1;
        rld_we_v[1] = wr_en && addr == RA_RLD2;
        flag_wr     = wr_en && addr == RA_FLAG;
    end

    drt_evt_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_in (evt_in),
        .level  (evt_lvl),
        .rise   (evt_rise)
    );

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        drt_down_counter #(.W(TW)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (run_v[i]),
            .step      (step_v[i]),
            .rld_we    (rld_we_v[i]),
            .rld_wdata (wdata[TW-1:0]),
            .count     (cnt_v[i]),
            .reload    (rld_v[i]),
            .uf        (uf_v[i])
        );

        // Sticky flag: set on underflow (wins), cleared by write-one
        always_ff @(posedge clk) begin
            if (!rst_n)                       flags[i] <= 1'b0;
            else if (uf_v[i])                 flags[i] <= 1'b1;
            else if (flag_wr && wdata[i])     flags[i] <= 1'b0;
        end

        assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !(flag_wr && wdata[i])) |=> flags[i]);
        assert_uf_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
            uf_v[i] |=> flags[i]);
    end

    drt_toggle u_tgl (
        .clk   (clk),
        .rst_n (rst_n),
        .uf_a  (uf_v[0]),
        .uf_b  (uf_v[1]),
        .sel_b (ctrl[CB_TSEL]),
        .tgl   (tgl)
    );

    // Output pins
    always_comb begin
        cnt_out = tgl;
        cnt_oe  = ctrl[CB_OE];
        irq_t1  = flags[0];
        irq_t2  = flags[1];
    end

    // Read mux
    always_comb begin
        rdata = '0;
        case (addr)
            RA_CTRL: rdata = DATA_W'(ctrl);
            RA_RLD1: rdata = DATA_W'(rld_v[0]);
            RA_RLD2: rdata = DATA_W'(rld_v[1]);
            RA_CNT1: rdata = DATA_W'(cnt_v[0]);
            RA_CNT2: rdata = DATA_W'(cnt_v[1]);
            RA_FLAG: rdata = DATA_W'(flags);
            RA_PIN:  rdata = DATA_W'({tgl, evt_lvl});
            default: rdata = '0;
        endcase
    end

    assert_evt_no_t1_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !rld_we_v[0]) |=> $stable(cnt_v[0]));
    assert_oe_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RA_CTRL) |=> cnt_oe == $past(wdata[CB_OE]));
endmodule

// File: tb/sim_dual_reload_timer.sv
module sim_dual_reload_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       tick_en = 1'b0;
    logic       evt_in = 1'b0;
    logic       cnt_out, cnt_oe, irq_t1, irq_t2;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic tgl_exp = 1'b0;
    logic [7:0] v;

    always #(CLK_PERIOD/2) clk = !clk;

    dual_reload_timer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tick_en(tick_en), .evt_in(evt_in), .cnt_out(cnt_out),
        .cnt_oe(cnt_oe), .irq_t1(irq_t1), .irq_t2(irq_t2)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    // One event pulse: high for three cycles, low for three
    task automatic pulse();
        @(negedge clk);
        evt_in = 1'b1;
        repeat (3) @(negedge clk);
        evt_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            chk("R1 reset read", v, 8'h00);
        end
        chk("R1 irq_t1", {7'd0, irq_t1}, 8'd0);
        chk("R1 irq_t2", {7'd0, irq_t2}, 8'd0);
        chk("R1 cnt_oe", {7'd0, cnt_oe}, 8'd0);
        chk("R1 cnt_out", {7'd0, cnt_out}, 8'd0);

        // Timer 1 sweep over reload values (R2, R3, R4, R5, R8)
        for (int n = 0; n <= 12; n++) begin
            wr(3'd0, 8'h00);
            wr(3'd1, 8'(n));
            rd(3'd3, v);
            chk("R5 stopped reload write loads count", v, 8'(n));
            wr(3'd0, 8'h01);
            rd(3'd0, v);
            chk("R9 ctrl readback", v, 8'h01);
            for (int k = 0; k <= n; k++) begin
                rd(3'd3, v);
                chk("R2 t1 decrement", v, 8'(n - k));
                chk("R3 no flag before underflow", {7'd0, irq_t1}, 8'd0);
                tick(1);
            end
            tgl_exp = !tgl_exp;
            rd(3'd3, v);
            chk("R3 t1 reload after underflow", v, 8'(n));
            chk("R3 irq_t1 set", {7'd0, irq_t1}, 8'd1);
            rd(3'd6, v);
            chk("R8 toggle on t1 underflow", {7'd0, v[1]}, {7'd0, tgl_exp});
            wr(3'd5, 8'h00);
            chk("R4 zero write keeps flag", {7'd0, irq_t1}, 8'd1);
            wr(3'd5, 8'h01);
            chk("R4 w1c clears flag", {7'd0, irq_t1}, 8'd0);
        end

        // R6 stopped timer holds
        wr(3'd0, 8'h00);
        tick(5);
        rd(3'd3, v);
        chk("R6 stopped t1 holds", v, 8'd12);

        // R5 write while running
        wr(3'd1, 8'd4);
        wr(3'd0, 8'h01);
        tick(2);
        wr(3'd1, 8'd9);
        rd(3'd3, v);
        chk("R5 running write leaves count", v, 8'd2);
        rd(3'd1, v);
        chk("R5 reload register updated", v, 8'd9);
        tick(3);
        rd(3'd3, v);
        chk("R5 new reload taken at underflow", v, 8'd9);
        tgl_exp = !tgl_exp;
        wr(3'd5, 8'h01);

        // Timer 2 internal sweep; toggle selects timer 1 so must not move
        wr(3'd0, 8'h00);
        for (int n = 0; n <= 6; n++) begin
            wr(3'd2, 8'(n));
            wr(3'd0, 8'h02);
            for (int k = 0; k <= n; k++) begin
                rd(3'd4, v);
                chk("R2 t2 decrement", v, 8'(n - k));
                tick(1);
            end
            rd(3'd4, v);
            chk("R3 t2 reload after underflow", v, 8'(n));
            chk("R3 irq_t2 set", {7'd0, irq_t2}, 8'd1);
            chk("R4 irq_t1 untouched", {7'd0, irq_t1}, 8'd0);
            rd(3'd6, v);
            chk("R8 unselected t2 underflow ignored", {7'd0, v[1]}, {7'd0, tgl_exp});
            wr(3'd5, 8'h02);
            chk("R4 w1c clears t2", {7'd0, irq_t2}, 8'd0);
            wr(3'd0, 8'h00);
        end

        // R8 toggle selects timer 2
        wr(3'd0, 8'h0A);
        tick(7);
        tgl_exp = !tgl_exp;
        rd(3'd6, v);
        chk("R8 toggle on t2 underflow", {7'd0, v[1]}, {7'd0, tgl_exp});
        wr(3'd5, 8'h03);

        // R9 output enable and toggle output
        wr(3'd0, 8'h10);
        chk("R9 cnt_oe high", {7'd0, cnt_oe}, 8'd1);
        chk("R9 cnt_out is toggle", {7'd0, cnt_out}, {7'd0, tgl_exp});
        rd(3'd0, v);
        chk("R9 ctrl readback", v, 8'h10);

        // R10 pin input readable while output enabled
        @(negedge clk);
        evt_in = 1'b1;
        @(negedge clk);
        rd(3'd6, v);
        chk("R10 one flop not yet visible", {7'd0, v[0]}, 8'd0);
        @(negedge clk);
        rd(3'd6, v);
        chk("R10 pin level after two flops", {7'd0, v[0]}, 8'd1);
        evt_in = 1'b0;
        repeat (2) @(negedge clk);
        rd(3'd6, v);
        chk("R10 pin low again", {7'd0, v[0]}, 8'd0);
        rd(3'd4, v);
        chk("R6 stopped t2 ignores event", v, 8'd6);
        wr(3'd0, 8'h00);
        chk("R9 cnt_oe low", {7'd0, cnt_oe}, 8'd0);

        // R7 event counting
        wr(3'd2, 8'd5);
        wr(3'd1, 8'd12);
        wr(3'd0, 8'h07);
        tick(4);
        rd(3'd4, v);
        chk("R7 ticks ignored in event mode", v, 8'd5);
        rd(3'd3, v);
        chk("R7 t1 still ticks", v, 8'd8);
        for (int e = 1; e <= 5; e++) begin
            pulse();
            rd(3'd4, v);
            chk("R7 event step", v, 8'(5 - e));
            rd(3'd3, v);
            chk("R7 events do not step t1", v, 8'd8);
        end
        chk("R7 no flag before underflow", {7'd0, irq_t2}, 8'd0);
        pulse();
        rd(3'd4, v);
        chk("R7 event underflow reloads", v, 8'd5);
        chk("R7 event underflow flag", {7'd0, irq_t2}, 8'd1);

        // R7 exact latency: decrement on third edge after rise
        @(negedge clk);
        evt_in = 1'b1;
        repeat (2) @(negedge clk);
        rd(3'd4, v);
        chk("R7 not yet counted after two edges", v, 8'd5);
        @(negedge clk);
        rd(3'd4, v);
        chk("R7 counted on third edge", v, 8'd4);
        evt_in = 1'b0;
        repeat (3) @(negedge clk);

        finish_run();
    end
endmodule